// File: doc/BRIEF.md
# Strap-Sampled Mode Register and External Request Controller

This block serves four shared external pins that play two roles. While the synchronous reset is held, the pins are mode straps. On the first clock edge after reset falls, their synchronised values are loaded into a 4-bit mode register, which selects one of sixteen start-up modes. From then on, that register changes only through a write port.

After reset, pin 0 becomes request line A and pin 1 becomes request line B. Both lines are active low. Each line can detect either a low level or a falling edge. An edge sets a sticky flag that stays set until an acknowledge pulse clears it. A per-line mask gates the pending output that goes to the core. It does not gate the wake logic.

A registered wake output releases the core from its standby states, with different rights per line. Line A ends both WAIT and STOP. Line B ends WAIT only.

Top module: `pin_mode_irq_ctl`

## Requirements
- R1: While `rst` is high, `mode_q`, `irq_pend` and `wake` are all zero.
- R2: On the first rising clock edge with `rst` low after reset, `mode_q[i]` takes the level of `pins[i]` (1 = high). This holds when the pins were stable for at least three cycles before the release.
- R3: After the capture, changes on `pins` never alter `mode_q`.
- R4: A clock edge with `mode_wr` high loads `mode_wdata` into `mode_q`. The capture cycle takes priority over a write.
- R5: In level mode (`cfg_edge[i]`=0), unmasked `irq_pend[i]` is high while pin i is low. The output follows the pin three clock edges later.
- R6: In edge mode (`cfg_edge[i]`=1), a high-to-low transition on pin i sets `irq_pend[i]`. It stays set after the pin returns high.
- R7: A one-cycle pulse on `irq_ack[i]` clears an edge-mode pending flag on the next edge. Line i is bit i of `irq_ack`.
- R8: With `cfg_mask[i]`=1, `irq_pend[i]` stays low. A flag captured while masked appears once the mask is cleared.
- R9: A request on line A raises `wake` one edge later when `standby` is WAIT (2'b01) or STOP (2'b10). This holds even when line A is masked.
- R10: A request on line B raises `wake` only when `standby` is WAIT. It never does so in STOP, and neither line raises it in RUN (2'b00).
- R11: A strap held low through the release of reset does not count as a falling edge in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | 4 | Shared pins: mode straps in reset, pins 0/1 are active-low requests A/B afterwards |
| cfg_edge | input | 2 | Per line: 1 = falling-edge detection, 0 = low-level detection |
| cfg_mask | input | 2 | Per line: 1 = pending output suppressed |
| irq_ack | input | 2 | Per line clear pulse for the edge flag |
| standby | input | 2 | Core state: 00 RUN, 01 WAIT, 10 STOP |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode register write data |
| mode_q | output | 4 | Mode register |
| irq_pend | output | 2 | Masked pending requests to the core |
| wake | output | 1 | Registered standby release |

## Verification
The bench holds strap 0 low through the release of reset with line A in edge mode. A design that seeds the previous sample from reset would report a spurious edge there. It toggles the pins after capture to catch a mode register that keeps tracking the straps. It sets an edge flag while the line is masked and then unmasks it, which exposes a mask that clears or blocks the flag instead of gating only the output. Finally, it drives line B in STOP and line A while masked, to catch wake logic that shares rights between the lines or uses the masked path.

// File: rtl/pmi_pkg.sv
package pmi_pkg;
  typedef enum logic [1:0] {
    SB_RUN  = 2'b00,
    SB_WAIT = 2'b01,
    SB_STOP = 2'b10
  } standby_e;
endpackage

// File: rtl/pmi_sync.sv
module pmi_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) stage[0] <= d;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) stage[s] <= stage[s-1];
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pmi_mode_latch.sv
module pmi_mode_latch #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] straps,
  input  logic              wr,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q
);
  logic rst_d;
  logic capture;

  always_ff @(posedge clk) rst_d <= rst;

  assign capture = rst_d & ~rst;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (capture) mode_q <= straps;
    else if (wr)      mode_q <= wdata;
  end

  // R2
  capture_loads_straps_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> mode_q == $past(straps));

  // R3
  mode_held_chk: assert property (@(posedge clk) disable iff (rst)
    (!capture && !wr) |=> $stable(mode_q));
endmodule

// File: rtl/pmi_irq_line.sv
module pmi_irq_line (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic mask,
  input  logic ack,
  output logic req,
  output logic pend
);
  logic prev;
  logic fall;
  logic flag;
  logic flag_nxt;

  always_ff @(posedge clk) prev <= pin_s;

  assign fall = prev & ~pin_s;

  always_comb begin
    if (!edge_mode)  flag_nxt = 1'b0;
    else if (fall)   flag_nxt = 1'b1;
    else if (ack)    flag_nxt = 1'b0;
    else             flag_nxt = flag;
  end

  assign req = edge_mode ? flag : ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      pend <= 1'b0;
    end else begin
      flag <= flag_nxt;
      pend <= (edge_mode ? flag_nxt : ~pin_s) & ~mask;
    end
  end

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && ack && !fall) |=> !flag);

  // R8
  mask_gates_chk: assert property (@(posedge clk) disable iff (rst)
    mask |=> !pend);
endmodule

// File: rtl/pin_mode_irq_ctl.sv
module pin_mode_irq_ctl #(
  parameter int NPINS       = 4,
  parameter int NIRQ        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins,
  input  logic [NIRQ-1:0]  cfg_edge,
  input  logic [NIRQ-1:0]  cfg_mask,
  input  logic [NIRQ-1:0]  irq_ack,
  input  logic [1:0]       standby,
  input  logic             mode_wr,
  input  logic [NPINS-1:0] mode_wdata,
  output logic [NPINS-1:0] mode_q,
  output logic [NIRQ-1:0]  irq_pend,
  output logic             wake
);
  import pmi_pkg::*;

  localparam int MODE_W = NPINS;

  logic [NPINS-1:0] pins_s;
  logic [NIRQ-1:0]  req;
  logic             in_wait;
  logic             in_stop;

  pmi_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (pins),
    .q   (pins_s)
  );

  pmi_mode_latch #(.MODE_W(MODE_W)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .straps (pins_s),
    .wr     (mode_wr),
    .wdata  (mode_wdata),
    .mode_q (mode_q)
  );

  generate
    for (genvar i = 0; i < NIRQ; i++) begin : g_line
      pmi_irq_line u_line (
        .clk       (clk),
        .rst       (rst),
        .pin_s     (pins_s[i]),
        .edge_mode (cfg_edge[i]),
        .mask      (cfg_mask[i]),
        .ack       (irq_ack[i]),
        .req       (req[i]),
        .pend      (irq_pend[i])
      );
    end
  endgenerate

  assign in_wait = (standby == SB_WAIT);
  assign in_stop = (standby == SB_STOP);

  // Line 0 ends WAIT and STOP; line 1 ends WAIT only.
  always_ff @(posedge clk) begin
    if (rst) wake <= 1'b0;
    else     wake <= (req[0] & (in_wait | in_stop)) | (req[1] & in_wait);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (mode_q == '0 && irq_pend == '0 && !wake));

  // R10
  stop_wake_rights_chk: assert property (@(posedge clk) disable iff (rst)
    (in_stop && !req[0]) |=> !wake);

  // R10
  run_no_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (standby == SB_RUN) |=> !wake);
endmodule

// File: tb/pin_mode_irq_ctl_test.sv
module pin_mode_irq_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] pins;
  logic [1:0] cfg_edge, cfg_mask, irq_ack, standby;
  logic       mode_wr;
  logic [3:0] mode_wdata;
  logic [3:0] mode_q;
  logic [1:0] irq_pend;
  logic       wake;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_mode_irq_ctl uut (
    .clk(clk), .rst(rst), .pins(pins), .cfg_edge(cfg_edge),
    .cfg_mask(cfg_mask), .irq_ack(irq_ack), .standby(standby),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_q(mode_q),
    .irq_pend(irq_pend), .wake(wake)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_and_capture();
    pins = 4'b0110; cfg_edge = 2'b11; cfg_mask = 2'b00; irq_ack = 2'b00;
    standby = 2'b00; mode_wr = 1'b0; mode_wdata = 4'h0; rst = 1'b1;
    cyc(6);
    check("R1 mode_q", mode_q, 0);
    check("R1 irq_pend", irq_pend, 0);
    check("R1 wake", wake, 0);
    rst = 1'b0;
    cyc(2);
    check("R2 captured mode", mode_q, 6);
    cyc(4);
    check("R11 no false edge on held strap", irq_pend, 0);
  endtask

  task automatic t_mode_hold_and_write();
    pins = 4'b1111; cyc(4);
    check("R3 mode after pin change", mode_q, 6);
    pins = 4'b0011; cyc(4);
    check("R3 mode after second change", mode_q, 6);
    pins = 4'b1111;
    mode_wr = 1'b1; mode_wdata = 4'h9; cyc(1);
    mode_wr = 1'b0; cyc(1);
    check("R4 written mode", mode_q, 9);
    cyc(3);
    check("R4 mode held after write", mode_q, 9);
  endtask

  task automatic t_level();
    cfg_edge = 2'b00; cyc(4);
    check("R5 idle level", irq_pend, 0);
    pins[0] = 1'b0; cyc(4);
    check("R5 line A low", irq_pend, 1);
    pins[0] = 1'b1; pins[1] = 1'b0; cyc(4);
    check("R5 line B low only", irq_pend, 2);
    pins[1] = 1'b1; cyc(4);
    check("R5 released", irq_pend, 0);
  endtask

  task automatic t_edge_ack();
    cfg_edge = 2'b11; cyc(2);
    pins[1] = 1'b0; cyc(3); pins[1] = 1'b1; cyc(4);
    check("R6 sticky edge B", irq_pend, 2);
    cyc(5);
    check("R6 still pending", irq_pend, 2);
    irq_ack = 2'b10; cyc(1); irq_ack = 2'b00; cyc(1);
    check("R7 ack clears B", irq_pend, 0);
  endtask

  task automatic t_mask();
    cfg_mask = 2'b01;
    pins[0] = 1'b0; cyc(3); pins[0] = 1'b1; cyc(4);
    check("R8 masked A hidden", irq_pend, 0);
    cfg_mask = 2'b00; cyc(2);
    check("R8 unmasked flag shows", irq_pend, 1);
    irq_ack = 2'b01; cyc(1); irq_ack = 2'b00; cyc(1);
    check("R7 ack clears A", irq_pend, 0);
  endtask

  task automatic t_wake();
    cfg_edge = 2'b00; cfg_mask = 2'b11; standby = 2'b01; cyc(4);
    check("R9 no request no wake", wake, 0);
    pins[0] = 1'b0; cyc(4);
    check("R9 A wakes WAIT while masked", wake, 1);
    check("R8 masked level hidden", irq_pend, 0);
    standby = 2'b10; cyc(2);
    check("R9 A wakes STOP", wake, 1);
    standby = 2'b00; cyc(2);
    check("R10 no wake in RUN", wake, 0);
    pins[0] = 1'b1; pins[1] = 1'b0; standby = 2'b10; cyc(4);
    check("R10 B does not wake STOP", wake, 0);
    standby = 2'b01; cyc(2);
    check("R10 B wakes WAIT", wake, 1);
    pins[1] = 1'b1; cyc(4);
    check("R10 wake drops", wake, 0);
  endtask

  initial begin
    t_reset_and_capture();
    t_mode_hold_and_write();
    t_level();
    t_edge_ack();
    t_mask();
    t_wake();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule